// File: doc/BRIEF.md
# Tiled Element-wise Operation Sequencer

This block drives one tiled unary element-wise job over an M×N matrix. After a start pulse it latches the job description: the matrix size, the tile size, the bytes per element, the source and destination base addresses, a pipeline tag and two enable flags. It works out how many tiles the job has, then hands the tiles out one at a time in row-major order. Each tile goes either to a shared input-DMA command queue or, when input DMA is switched off, as a fetch trigger straight to the next stage. Every issued item carries its tile index, the pipeline tag, the tile's byte count, its effective height and width, and its source and destination addresses. The pipeline tag lets several sequencers share the same engines.

Completion replies from the downstream write-back path are counted while the job runs. Replies for earlier tiles may arrive while later tiles are still being issued. Done is raised once the issue walk has finished and the reply count matches the tile count. At that point the value of a free-running cycle counter is captured as the done time. The math datapath and the DMA engines lie outside this block.

Top module: `tile_op_seq`

## Requirements
- R1: While reset is held and right after it is released, both issue valids are low, done is low and the done time is zero.
- R2: The job has ceil(M/tile_m) row tiles and ceil(N/tile_n) column tiles. Exactly that many items are issued, in row-major order. Item k carries tile id k, so tile id = row × column-tile count + column.
- R3: Every item reports an effective height of min(tile_m, M) and an effective width of min(tile_n, N). Its byte count is height × width × bytes per element. Edge tiles are not trimmed.
- R4: The source address of the tile in row r and column c is the source base + (r × tile_m × N + c × tile_n) × bytes per element. The destination address is formed the same way from the destination base. Both wrap at the address width.
- R5: With the input-DMA enable set at start, every tile goes out on the DMA request channel. The operand code is 2'd1 (operand A) and the pipeline tag is the one latched at start. The trigger valid stays low.
- R6: With the input-DMA enable clear at start, every tile goes out on the trigger channel with source code 2'd2 (sequencer). The DMA request valid stays low. The two valids are never high together.
- R7: An issued item keeps its valid high, and all of its fields unchanged, until the selected channel's ready is sampled high.
- R8: Done rises only after all tiles have been accepted and as many completion replies as tiles have been received while the job is busy. Replies are accepted while issue is still in progress.
- R9: The done time equals the number of clock edges since reset release, minus one, at the edge where done is set.
- R10: A start pulse while a job is in progress is ignored. The issued stream, tags and addresses keep following the job that was accepted.
- R11: Done stays high until the next accepted start. An accepted start of a nonzero job clears done at that edge.
- R12: If M, N, tile_m or tile_n is zero at start, the job has no tiles. Nothing is issued, and done is high from the first edge after the start pulse, with its time recorded.
- R13: Each issued item carries the write-back enable value latched at start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; taken only when idle |
| m_i | input | DIM_W | Matrix rows |
| n_i | input | DIM_W | Matrix columns |
| tile_m_i | input | DIM_W | Tile rows |
| tile_n_i | input | DIM_W | Tile columns |
| bpe_i | input | BPE_W | Bytes per element |
| src_base_i | input | ADDR_W | Source base address |
| dst_base_i | input | ADDR_W | Destination base address |
| pipe_id_i | input | PID_W | Pipeline tag |
| dma_in_en_i | input | 1 | 1: issue to DMA queue, 0: issue as fetch trigger |
| wb_en_i | input | 1 | Write-back enable carried with each tile |
| dma_req_valid_o | output | 1 | DMA request valid |
| dma_req_ready_i | input | 1 | DMA request ready |
| dma_operand_o | output | 2 | Operand code, 2'd1 = A |
| trig_valid_o | output | 1 | Fetch trigger valid |
| trig_ready_i | input | 1 | Fetch trigger ready |
| trig_source_o | output | 2 | Source code, 2'd2 = sequencer |
| tile_id_o | output | 2*DIM_W | Tile index |
| pipe_id_o | output | PID_W | Latched pipeline tag |
| src_addr_o | output | ADDR_W | Tile source address |
| dst_addr_o | output | ADDR_W | Tile destination address |
| tile_bytes_o | output | 2*DIM_W+BPE_W | Tile transfer size in bytes |
| tile_rows_o | output | DIM_W | Effective tile height |
| tile_cols_o | output | DIM_W | Effective tile width |
| wb_en_o | output | 1 | Latched write-back enable |
| reply_valid_i | input | 1 | One completion reply per high cycle |
| done_o | output | 1 | Job complete |
| done_time_o | output | TS_W | Cycle count captured at completion |

## Verification
The bench builds the block with DIM_W=8, ADDR_W=24 and TS_W=24. With 8-bit dimensions, the ceiling-division setup walk finishes in a few cycles. The 24-bit addresses keep every expected address easy to compute as a wrapped sum. The jobs include 3×3, 1×1 and 3×3 tile grids. They cover both issue channels, a tile wider than the matrix, ready that stalls in two different patterns, and replies that either follow the accepts closely or are held back until the last tile is out. They also cover a start pulse that arrives mid-job and a zero-row job.

// File: rtl/tile_op_seq_pkg.sv
package tile_op_seq_pkg;
  localparam logic [1:0] TAG_OPERAND_A = 2'd1;
  localparam logic [1:0] TAG_SRC_SEQ   = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ISSUE,
    ST_WAIT
  } seq_state_e;
endpackage

// File: rtl/tile_op_seq_geom.sv
// Latches job geometry; ceil-divides by repeated addition during setup.
module tile_op_seq_geom #(
  parameter int DIM_W   = 16,
  parameter int BPE_W   = 4,
  parameter int ADDR_W  = 32,
  parameter int TID_W   = 2 * DIM_W,
  parameter int BYTES_W = 2 * DIM_W + BPE_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               step_i,
  input  logic [DIM_W-1:0]   m_i,
  input  logic [DIM_W-1:0]   n_i,
  input  logic [DIM_W-1:0]   tm_i,
  input  logic [DIM_W-1:0]   tn_i,
  input  logic [BPE_W-1:0]   bpe_i,
  output logic [DIM_W-1:0]   rows_o,
  output logic [DIM_W-1:0]   cols_o,
  output logic [TID_W-1:0]   total_o,
  output logic [DIM_W-1:0]   eff_h_o,
  output logic [DIM_W-1:0]   eff_w_o,
  output logic [BYTES_W-1:0] bytes_o,
  output logic [ADDR_W-1:0]  row_stride_o,
  output logic [ADDR_W-1:0]  col_stride_o,
  output logic               done_o
);
  logic [DIM_W-1:0]   m_q, n_q, tm_q, tn_q;
  logic [DIM_W:0]     r_acc_q, c_acc_q;
  logic [DIM_W-1:0]   eff_h_c, eff_w_c;
  logic [BYTES_W-1:0] bytes_c;
  logic [ADDR_W-1:0]  row_stride_c, col_stride_c;
  logic               r_open, c_open;

  assign eff_h_c      = (tm_i < m_i) ? tm_i : m_i;
  assign eff_w_c      = (tn_i < n_i) ? tn_i : n_i;
  assign bytes_c      = BYTES_W'(eff_h_c) * BYTES_W'(eff_w_c) * BYTES_W'(bpe_i);
  assign row_stride_c = ADDR_W'(tm_i) * ADDR_W'(n_i) * ADDR_W'(bpe_i);
  assign col_stride_c = ADDR_W'(tn_i) * ADDR_W'(bpe_i);

  assign r_open = r_acc_q < {1'b0, m_q};
  assign c_open = c_acc_q < {1'b0, n_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_q <= '0; n_q <= '0; tm_q <= '0; tn_q <= '0;
      r_acc_q <= '0; c_acc_q <= '0;
      rows_o <= '0; cols_o <= '0;
      eff_h_o <= '0; eff_w_o <= '0; bytes_o <= '0;
      row_stride_o <= '0; col_stride_o <= '0;
    end else if (load_i) begin
      m_q <= m_i; n_q <= n_i; tm_q <= tm_i; tn_q <= tn_i;
      r_acc_q <= '0; c_acc_q <= '0;
      rows_o <= '0; cols_o <= '0;
      eff_h_o <= eff_h_c; eff_w_o <= eff_w_c; bytes_o <= bytes_c;
      row_stride_o <= row_stride_c; col_stride_o <= col_stride_c;
    end else if (step_i) begin
      if (r_open) begin
        r_acc_q <= r_acc_q + {1'b0, tm_q};
        rows_o  <= rows_o + 1'b1;
      end
      if (c_open) begin
        c_acc_q <= c_acc_q + {1'b0, tn_q};
        cols_o  <= cols_o + 1'b1;
      end
    end
  end

  assign done_o  = !r_open && !c_open;
  assign total_o = TID_W'(rows_o) * TID_W'(cols_o);
endmodule

// File: rtl/tile_op_seq_walk.sv
// Row-major tile walker with incremental address offsets.
module tile_op_seq_walk #(
  parameter int DIM_W  = 16,
  parameter int ADDR_W = 32,
  parameter int TID_W  = 2 * DIM_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  logic [DIM_W-1:0]  rows_i,
  input  logic [DIM_W-1:0]  cols_i,
  input  logic [ADDR_W-1:0] row_stride_i,
  input  logic [ADDR_W-1:0] col_stride_i,
  input  logic [ADDR_W-1:0] src_base_i,
  input  logic [ADDR_W-1:0] dst_base_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic              last_o,
  output logic [TID_W-1:0]  tile_o,
  output logic [ADDR_W-1:0] src_o,
  output logic [ADDR_W-1:0] dst_o
);
  logic              active_q;
  logic [DIM_W-1:0]  r_q, c_q;
  logic [TID_W-1:0]  tile_q;
  logic [ADDR_W-1:0] row_off_q, col_off_q, off;
  logic              fire, last_col, last_row;

  assign fire     = active_q && ready_i;
  assign last_col = c_q == (cols_i - DIM_W'(1));
  assign last_row = r_q == (rows_i - DIM_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      r_q <= '0; c_q <= '0; tile_q <= '0;
      row_off_q <= '0; col_off_q <= '0;
    end else if (launch_i) begin
      active_q <= 1'b1;
      r_q <= '0; c_q <= '0; tile_q <= '0;
      row_off_q <= '0; col_off_q <= '0;
    end else if (fire) begin
      tile_q <= tile_q + 1'b1;
      if (last_col) begin
        c_q       <= '0;
        col_off_q <= '0;
        r_q       <= r_q + 1'b1;
        row_off_q <= row_off_q + row_stride_i;
        if (last_row) active_q <= 1'b0;
      end else begin
        c_q       <= c_q + 1'b1;
        col_off_q <= col_off_q + col_stride_i;
      end
    end
  end

  assign off     = row_off_q + col_off_q;
  assign valid_o = active_q;
  assign last_o  = fire && last_col && last_row;
  assign tile_o  = tile_q;
  assign src_o   = src_base_i + off;
  assign dst_o   = dst_base_i + off;
endmodule

// File: rtl/tile_op_seq_track.sv
// Reply counter, done flag and completion timestamp.
module tile_op_seq_track #(
  parameter int TID_W = 32,
  parameter int TS_W  = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic             zero_i,
  input  logic             count_en_i,
  input  logic             reply_i,
  input  logic             check_i,
  input  logic [TID_W-1:0] total_i,
  output logic             hit_o,
  output logic             done_o,
  output logic [TS_W-1:0]  time_o
);
  logic [TID_W-1:0] cnt_q;
  logic [TS_W-1:0]  cyc_q;

  assign hit_o = check_i && (cnt_q == total_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cyc_q <= '0;
    else         cyc_q <= cyc_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_o <= 1'b0;
      time_o <= '0;
    end else if (arm_i) begin
      cnt_q  <= '0;
      done_o <= zero_i;
      if (zero_i) time_o <= cyc_q;
    end else begin
      if (count_en_i && reply_i) cnt_q <= cnt_q + 1'b1;
      if (hit_o) begin
        done_o <= 1'b1;
        time_o <= cyc_q;
      end
    end
  end
endmodule

// File: rtl/tile_op_seq.sv
module tile_op_seq
  import tile_op_seq_pkg::*;
#(
  parameter int DIM_W  = 16,
  parameter int BPE_W  = 4,
  parameter int ADDR_W = 32,
  parameter int PID_W  = 4,
  parameter int TS_W   = 32
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         start_i,
  input  logic [DIM_W-1:0]             m_i,
  input  logic [DIM_W-1:0]             n_i,
  input  logic [DIM_W-1:0]             tile_m_i,
  input  logic [DIM_W-1:0]             tile_n_i,
  input  logic [BPE_W-1:0]             bpe_i,
  input  logic [ADDR_W-1:0]            src_base_i,
  input  logic [ADDR_W-1:0]            dst_base_i,
  input  logic [PID_W-1:0]             pipe_id_i,
  input  logic                         dma_in_en_i,
  input  logic                         wb_en_i,
  output logic                         dma_req_valid_o,
  input  logic                         dma_req_ready_i,
  output logic [1:0]                   dma_operand_o,
  output logic                         trig_valid_o,
  input  logic                         trig_ready_i,
  output logic [1:0]                   trig_source_o,
  output logic [2*DIM_W-1:0]           tile_id_o,
  output logic [PID_W-1:0]             pipe_id_o,
  output logic [ADDR_W-1:0]            src_addr_o,
  output logic [ADDR_W-1:0]            dst_addr_o,
  output logic [2*DIM_W+BPE_W-1:0]     tile_bytes_o,
  output logic [DIM_W-1:0]             tile_rows_o,
  output logic [DIM_W-1:0]             tile_cols_o,
  output logic                         wb_en_o,
  input  logic                         reply_valid_i,
  output logic                         done_o,
  output logic [TS_W-1:0]              done_time_o
);
  localparam int TID_W   = 2 * DIM_W;
  localparam int BYTES_W = 2 * DIM_W + BPE_W;

  seq_state_e        state_q;
  logic [PID_W-1:0]  pid_q;
  logic              dma_en_q, wb_q;
  logic [ADDR_W-1:0] src_q, dst_q;
  logic              accept, zero_job, busy;
  logic              geom_done, launch, walk_valid, walk_last, walk_ready, hit;
  logic [DIM_W-1:0]  rows, cols;
  logic [TID_W-1:0]  total;
  logic [ADDR_W-1:0] row_stride, col_stride;

  assign busy     = state_q != ST_IDLE;
  assign accept   = start_i && !busy;
  assign zero_job = (m_i == '0) || (n_i == '0) || (tile_m_i == '0) || (tile_n_i == '0);
  assign launch   = (state_q == ST_SETUP) && geom_done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      pid_q    <= '0;
      dma_en_q <= 1'b0;
      wb_q     <= 1'b0;
      src_q    <= '0;
      dst_q    <= '0;
    end else begin
      if (accept) begin
        pid_q    <= pipe_id_i;
        dma_en_q <= dma_in_en_i;
        wb_q     <= wb_en_i;
        src_q    <= src_base_i;
        dst_q    <= dst_base_i;
      end
      unique case (state_q)
        ST_IDLE:  if (accept && !zero_job) state_q <= ST_SETUP;
        ST_SETUP: if (geom_done)           state_q <= ST_ISSUE;
        ST_ISSUE: if (walk_last)           state_q <= ST_WAIT;
        ST_WAIT:  if (hit)                 state_q <= ST_IDLE;
        default:                           state_q <= ST_IDLE;
      endcase
    end
  end

  tile_op_seq_geom #(
    .DIM_W(DIM_W), .BPE_W(BPE_W), .ADDR_W(ADDR_W), .TID_W(TID_W), .BYTES_W(BYTES_W)
  ) u_geom (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (accept),
    .step_i       (state_q == ST_SETUP),
    .m_i          (m_i),
    .n_i          (n_i),
    .tm_i         (tile_m_i),
    .tn_i         (tile_n_i),
    .bpe_i        (bpe_i),
    .rows_o       (rows),
    .cols_o       (cols),
    .total_o      (total),
    .eff_h_o      (tile_rows_o),
    .eff_w_o      (tile_cols_o),
    .bytes_o      (tile_bytes_o),
    .row_stride_o (row_stride),
    .col_stride_o (col_stride),
    .done_o       (geom_done)
  );

  assign walk_ready = dma_en_q ? dma_req_ready_i : trig_ready_i;

  tile_op_seq_walk #(
    .DIM_W(DIM_W), .ADDR_W(ADDR_W), .TID_W(TID_W)
  ) u_walk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .launch_i     (launch),
    .rows_i       (rows),
    .cols_i       (cols),
    .row_stride_i (row_stride),
    .col_stride_i (col_stride),
    .src_base_i   (src_q),
    .dst_base_i   (dst_q),
    .ready_i      (walk_ready),
    .valid_o      (walk_valid),
    .last_o       (walk_last),
    .tile_o       (tile_id_o),
    .src_o        (src_addr_o),
    .dst_o        (dst_addr_o)
  );

  tile_op_seq_track #(
    .TID_W(TID_W), .TS_W(TS_W)
  ) u_track (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .arm_i      (accept),
    .zero_i     (zero_job),
    .count_en_i (busy),
    .reply_i    (reply_valid_i),
    .check_i    (state_q == ST_WAIT),
    .total_i    (total),
    .hit_o      (hit),
    .done_o     (done_o),
    .time_o     (done_time_o)
  );

  assign dma_req_valid_o = walk_valid && dma_en_q;
  assign trig_valid_o    = walk_valid && !dma_en_q;
  assign dma_operand_o   = TAG_OPERAND_A;
  assign trig_source_o   = TAG_SRC_SEQ;
  assign pipe_id_o       = pid_q;
  assign wb_en_o         = wb_q;
endmodule

// File: rtl/tile_op_seq_chk.sv
module tile_op_seq_chk #(
  parameter int TID_W  = 32,
  parameter int ADDR_W = 32,
  parameter int PID_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              busy_i,
  input logic              reply_valid_i,
  input logic              dma_req_valid_i,
  input logic              dma_req_ready_i,
  input logic              trig_valid_i,
  input logic              trig_ready_i,
  input logic [TID_W-1:0]  tile_id_i,
  input logic [ADDR_W-1:0] src_addr_i,
  input logic [ADDR_W-1:0] dst_addr_i,
  input logic [PID_W-1:0]  pipe_id_i,
  input logic              done_i
);
  logic [TID_W:0] iss_q, rep_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      iss_q <= '0;
      rep_q <= '0;
    end else if (start_i && !busy_i) begin
      iss_q <= '0;
      rep_q <= '0;
    end else begin
      if ((dma_req_valid_i && dma_req_ready_i) || (trig_valid_i && trig_ready_i))
        iss_q <= iss_q + 1'b1;
      if (reply_valid_i && busy_i) rep_q <= rep_q + 1'b1;
    end
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_quiet_R1: assert (!dma_req_valid_i && !trig_valid_i && !done_i);
    end
  end

  assert_dma_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_req_valid_i && !dma_req_ready_i) |=>
      (dma_req_valid_i && $stable(tile_id_i) && $stable(src_addr_i) && $stable(dst_addr_i)));

  assert_trig_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_valid_i && !trig_ready_i) |=>
      (trig_valid_i && $stable(tile_id_i) && $stable(src_addr_i) && $stable(dst_addr_i)));

  assert_one_channel_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({dma_req_valid_i, trig_valid_i}));

  assert_done_after_replies_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_i) |-> (rep_q == iss_q));

  assert_busy_start_ignored_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && start_i) |=> $stable(pipe_id_i));

  assert_done_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !start_i) |=> done_i);
endmodule

bind tile_op_seq tile_op_seq_chk #(
  .TID_W(TID_W), .ADDR_W(ADDR_W), .PID_W(PID_W)
) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .start_i         (start_i),
  .busy_i          (busy),
  .reply_valid_i   (reply_valid_i),
  .dma_req_valid_i (dma_req_valid_o),
  .dma_req_ready_i (dma_req_ready_i),
  .trig_valid_i    (trig_valid_o),
  .trig_ready_i    (trig_ready_i),
  .tile_id_i       (tile_id_o),
  .src_addr_i      (src_addr_o),
  .dst_addr_i      (dst_addr_o),
  .pipe_id_i       (pipe_id_o),
  .done_i          (done_o)
);

// File: tb/sim_tile_op_seq.sv
module sim_tile_op_seq;
  localparam int DIM_W  = 8;
  localparam int BPE_W  = 4;
  localparam int ADDR_W = 24;
  localparam int PID_W  = 4;
  localparam int TS_W   = 24;
  localparam int AMASK  = (1 << ADDR_W) - 1;

  typedef struct {
    int tile; int src; int dst; int bytes; int h; int w;
    bit dma; int pid; bit wb;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic start = 1'b0;
  logic [DIM_W-1:0] m = '0, n = '0, tm = '0, tn = '0;
  logic [BPE_W-1:0] bpe = '0;
  logic [ADDR_W-1:0] src = '0, dst = '0;
  logic [PID_W-1:0] pid = '0;
  logic dma_en = 1'b0, wb_en = 1'b0;
  logic dma_ready = 1'b0, trig_ready = 1'b0, reply = 1'b0;
  logic dma_valid, trig_valid, wb_o, done;
  logic [1:0] operand, source;
  logic [2*DIM_W-1:0] tile_id;
  logic [PID_W-1:0] pid_o;
  logic [ADDR_W-1:0] src_o, dst_o;
  logic [2*DIM_W+BPE_W-1:0] bytes_o;
  logic [DIM_W-1:0] rows_o, cols_o;
  logic [TS_W-1:0] done_time;

  int tests = 0, fails = 0;
  int cyc = 0;
  int pending = 0;
  int rmode = 0;
  bit hold_r = 1'b0, done_seen = 1'b0, done_prev = 1'b0, job_dma = 1'b0;
  exp_t sb[$];

  always #5 clk = ~clk;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  tile_op_seq #(
    .DIM_W(DIM_W), .BPE_W(BPE_W), .ADDR_W(ADDR_W), .PID_W(PID_W), .TS_W(TS_W)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .m_i(m), .n_i(n), .tile_m_i(tm), .tile_n_i(tn), .bpe_i(bpe),
    .src_base_i(src), .dst_base_i(dst), .pipe_id_i(pid),
    .dma_in_en_i(dma_en), .wb_en_i(wb_en),
    .dma_req_valid_o(dma_valid), .dma_req_ready_i(dma_ready), .dma_operand_o(operand),
    .trig_valid_o(trig_valid), .trig_ready_i(trig_ready), .trig_source_o(source),
    .tile_id_o(tile_id), .pipe_id_o(pid_o), .src_addr_o(src_o), .dst_addr_o(dst_o),
    .tile_bytes_o(bytes_o), .tile_rows_o(rows_o), .tile_cols_o(cols_o), .wb_en_o(wb_o),
    .reply_valid_i(reply), .done_o(done), .done_time_o(done_time)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Monitor / responder: one process owns ready, reply and the scoreboard pops.
  initial begin
    forever begin
      @(negedge clk);
      dma_ready  = (rmode == 0) ? 1'b1 : (rmode == 1) ? ((cyc % 3) != 1) : ((cyc % 2) == 0);
      trig_ready = dma_ready;
      if (job_dma ? trig_valid : dma_valid)
        chk(1'b0, job_dma ? "R5" : "R6", "valid on unused channel", 1, 0);
      if ((dma_valid && dma_ready) || (trig_valid && trig_ready)) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R2", "extra tile issued", int'(tile_id), -1);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(int'(tile_id) == e.tile, "R2", "tile id", int'(tile_id), e.tile);
          chk(int'(rows_o) == e.h, "R3", "tile height", int'(rows_o), e.h);
          chk(int'(cols_o) == e.w, "R3", "tile width", int'(cols_o), e.w);
          chk(int'(bytes_o) == e.bytes, "R3", "tile bytes", int'(bytes_o), e.bytes);
          chk(int'(src_o) == e.src, "R4", "src addr", int'(src_o), e.src);
          chk(int'(dst_o) == e.dst, "R4", "dst addr", int'(dst_o), e.dst);
          chk(dma_valid == e.dma, "R5", "dma channel used", int'(dma_valid), int'(e.dma));
          chk(trig_valid == !e.dma, "R6", "trigger channel used", int'(trig_valid), int'(!e.dma));
          if (e.dma) chk(operand == 2'd1, "R5", "operand code", int'(operand), 1);
          else       chk(source == 2'd2, "R6", "source code", int'(source), 2);
          chk(int'(pid_o) == e.pid, "R10", "pipeline tag", int'(pid_o), e.pid);
          chk(wb_o == e.wb, "R13", "wb flag", int'(wb_o), int'(e.wb));
        end
        pending++;
      end
      if (pending > 0 && !hold_r) begin
        reply = 1'b1;
        pending--;
      end else begin
        reply = 1'b0;
      end
      if (done && !done_prev) begin
        done_seen = 1'b1;
        chk(int'(done_time) == cyc - 1, "R9", "done time", int'(done_time), cyc - 1);
        chk(pending == 0 && !hold_r && sb.size() == 0, "R8", "done before all replies",
            pending + sb.size(), 0);
      end
      done_prev = done;
    end
  end

  task automatic set_job(input int mm, input int nn, input int tmm, input int tnn,
                         input int bb, input int s, input int d, input int p,
                         input bit de, input bit we);
    int rows, cols, h, w;
    m = DIM_W'(mm); n = DIM_W'(nn); tm = DIM_W'(tmm); tn = DIM_W'(tnn);
    bpe = BPE_W'(bb); src = ADDR_W'(s); dst = ADDR_W'(d); pid = PID_W'(p);
    dma_en = de; wb_en = we;
    if (mm == 0 || nn == 0 || tmm == 0 || tnn == 0) return;
    rows = (mm + tmm - 1) / tmm;
    cols = (nn + tnn - 1) / tnn;
    h = (tmm < mm) ? tmm : mm;
    w = (tnn < nn) ? tnn : nn;
    for (int r = 0; r < rows; r++) begin
      for (int c = 0; c < cols; c++) begin
        exp_t e;
        int off;
        off = (r * tmm * nn + c * tnn) * bb;
        e.tile = r * cols + c;
        e.src = (s + off) & AMASK;
        e.dst = (d + off) & AMASK;
        e.bytes = h * w * bb;
        e.h = h; e.w = w; e.dma = de; e.pid = p; e.wb = we;
        sb.push_back(e);
      end
    end
  endtask

  task automatic pulse_start();
    @(negedge clk);
    job_dma = dma_en;
    done_seen = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int guard = 0;
    while (!done_seen && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    if (!done_seen) chk(1'b0, req, "watchdog: done never rose", 0, 1);
    chk(sb.size() == 0, "R2", "tiles left unissued", sb.size(), 0);
  endtask

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!dma_valid && !trig_valid, "R1", "valid after reset", int'(dma_valid | trig_valid), 0);
    chk(!done, "R1", "done after reset", int'(done), 0);
    chk(done_time == '0, "R1", "done time after reset", int'(done_time), 0);

    // Job A: 10x7, 4x3 tiles, DMA path, free-flowing ready, prompt replies
    rmode = 0;
    set_job(10, 7, 4, 3, 2, 'h1000, 'h8000, 5, 1'b1, 1'b1);
    pulse_start();
    wait_done("R8");
    repeat (5) @(negedge clk);
    chk(done, "R11", "done held after completion", int'(done), 1);

    // Job B: tile wider than matrix, trigger path, stalling ready
    rmode = 1;
    set_job(8, 8, 8, 16, 4, 'hFFFFF0, 'h20, 9, 1'b0, 1'b1);
    pulse_start();
    chk(!done, "R11", "done cleared by new start", int'(done), 0);
    wait_done("R6");

    // Job C: replies held back, start while busy must be ignored
    rmode = 2;
    set_job(5, 9, 2, 4, 1, 'h300, 'h700, 3, 1'b1, 1'b0);
    hold_r = 1'b1;
    pulse_start();
    repeat (2) @(negedge clk);
    pid = 4'hE; m = 8'd1; n = 8'd1; dma_en = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    begin
      int guard = 0;
      while (sb.size() != 0 && guard < 2000) begin
        @(negedge clk);
        guard++;
      end
    end
    repeat (4) @(negedge clk);
    chk(!done, "R8", "done with replies outstanding", int'(done), 0);
    chk(!dma_valid && !trig_valid, "R10", "extra issue after busy start", int'(dma_valid | trig_valid), 0);
    hold_r = 1'b0;
    wait_done("R8");

    // Job D: zero rows -> immediate done
    set_job(0, 6, 2, 2, 1, 0, 0, 1, 1'b1, 1'b0);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done, "R12", "done one cycle after zero start", int'(done), 1);
    chk(int'(done_time) == cyc - 1, "R12", "zero-job done time", int'(done_time), cyc - 1);
    repeat (3) @(negedge clk);
    chk(!dma_valid && !trig_valid, "R12", "issue on zero job", int'(dma_valid | trig_valid), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1500000;
    chk(1'b0, "R8", "global watchdog expired", 0, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule